// File: doc/BRIEF.md
# Automatic Clock Gear Divider Selector

This block derives a slower system clock from a fast input clock. It produces a one-cycle-wide clock enable pulse, `tick_o`, once per output period. Downstream logic treats the pulse as the high phase of the divided clock. Because the pulse is one input cycle wide, the high phase always lasts one input cycle, and any further division only lengthens the low phase. Two 3-bit divide fields are provided: a fast (high-speed) field and a slow (low-speed) field. A field value of n divides by 2^n, so a value of 0 passes every input cycle through.

A source-select bit chooses the operating mode:
- **Select bit clear:** the block always runs from the fast field.
- **Select bit set:** the block gears automatically. It runs from the fast field while a fast condition holds, and falls back to the slow field when none holds. There are two fast conditions: a pending interrupt, and a clear power-save flag (normal operation). Each counts only while the request-enable mask is set.

The interrupt and power-save inputs pass through a two-stage synchronizer before they reach the selection logic. A new divider choice, whether from a field write or from a change of condition, is taken only when the current output period ends. A status output shows which field governs the current period.

The period engine is a three-state machine:
- **GS_LOAD** is the single cycle after reset. It always moves to GS_EDGE and latches the first selection.
- **GS_EDGE** is the pulse cycle. It goes back to GS_EDGE when the latched exponent is 0, latching a fresh selection. Otherwise it goes to GS_STRETCH and loads the low-phase count of 2^n − 2.
- **GS_STRETCH** counts down. When the count reaches 0 it moves to GS_EDGE and latches a fresh selection; otherwise it stays in GS_STRETCH.

Top module: `gear_clock_sel`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, `tick_o` is 0 and `fast_active_o` is 1.
- R2: With `src_sel_i` = 0, every period uses `hi_div_i` and `fast_active_o` is 1, whatever the mask, interrupt and power-save inputs are.
- R3: A governing field value of 0 makes `tick_o` high on every input cycle.
- R4: A governing field value of n (0 to 7) gives an output period of exactly 2^n input cycles, with `tick_o` high for exactly one of them.
- R5: With `src_sel_i` = 1, `req_en_i` = 1 and `irq_pend_i` = 1, the periods use `hi_div_i` and `fast_active_o` is 1.
- R6: With `src_sel_i` = 1, `req_en_i` = 1 and `pwr_save_i` = 0, the periods use `hi_div_i` and `fast_active_o` is 1.
- R7: With `src_sel_i` = 1 and `req_en_i` = 0, the periods use `lo_div_i` and `fast_active_o` is 0, whatever the interrupt and power-save inputs are.
- R8: With `src_sel_i` = 1, `req_en_i` = 1, `irq_pend_i` = 0 and `pwr_save_i` = 1, the periods use `lo_div_i` and `fast_active_o` is 0.
- R9: A change of selection or of a field takes effect only at a period boundary. A running period keeps its length, and `fast_active_o` stays constant within it.
- R10: A change on `irq_pend_i` or `pwr_save_i` reaches the selection logic after two clock edges. It is latched at the third edge after it is driven, if that edge is a period boundary.
- R11: Rewriting either divide field while running changes the output period at the next boundary, with no reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hi_div_i | input | DIV_W | High-speed divide exponent (ratio 2^n) |
| lo_div_i | input | DIV_W | Low-speed divide exponent (ratio 2^n) |
| src_sel_i | input | 1 | 0: always high-speed field; 1: automatic gearing |
| req_en_i | input | 1 | Mask enabling both high-speed conditions |
| irq_pend_i | input | 1 | Interrupt pending, asynchronous |
| pwr_save_i | input | 1 | Power-save flag, asynchronous; 0 means normal operation |
| tick_o | output | 1 | One-cycle pulse forming the high phase of each output period |
| fast_active_o | output | 1 | 1 when the current period is governed by the high-speed field |

## Verification
The bench builds the block with its default parameters: 3-bit exponent fields and a two-stage synchronizer. With these defaults every ratio from 1 to 128 is reachable in a short run, so the longest 128-cycle period and the divide-by-one case are both measured directly. A single interrupt pulse then exposes the exact synchronizer latency. A pseudo-random phase rewrites the fields and conditions at arbitrary points inside periods. There, a behavioural model fed by queues of past inputs confirms that every period keeps the length it started with.

// File: rtl/gear_pkg.sv
package gear_pkg;

    // Period engine states
    typedef enum logic [1:0] {
        GS_LOAD    = 2'd0,   // first cycle after reset
        GS_EDGE    = 2'd1,   // pulse (high phase) cycle
        GS_STRETCH = 2'd2    // extended low phase
    } gear_state_e;

endpackage

// File: rtl/gear_sync.sv
module gear_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    generate
        if (STAGES < 2) begin : g_bad_depth
            initial $error("gear_sync needs at least two stages");
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/gear_select.sv
module gear_select #(
    parameter int DIV_W = 3
) (
    input  logic             src_sel_i,
    input  logic             req_en_i,
    input  logic             irq_s_i,
    input  logic             psave_s_i,
    input  logic [DIV_W-1:0] hi_div_i,
    input  logic [DIV_W-1:0] lo_div_i,
    output logic             want_fast_o,
    output logic [DIV_W-1:0] sel_div_o
);

    logic irq_req;
    logic run_req;

    always_comb begin
        irq_req     = req_en_i & irq_s_i;
        run_req     = req_en_i & ~psave_s_i;
        want_fast_o = ~src_sel_i | irq_req | run_req;
        sel_div_o   = want_fast_o ? hi_div_i : lo_div_i;
    end

endmodule

// File: rtl/gear_divider.sv
module gear_divider
    import gear_pkg::*;
#(
    parameter int DIV_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             want_fast_i,
    input  logic [DIV_W-1:0] sel_div_i,
    output logic             tick_o,
    output logic             fast_o
);

    localparam int CNT_W = (1 << DIV_W) - 1;

    gear_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [DIV_W-1:0] div_q, div_d;
    logic             fast_q, fast_d;
    logic             latch;

    // low-phase count load: 2^d - 2 (used only for d >= 1)
    function automatic logic [CNT_W-1:0] stretch_len(input logic [DIV_W-1:0] d);
        logic [CNT_W:0] full;
        full    = '0;
        full[d] = 1'b1;
        full    = full - (CNT_W + 1)'(2);
        return full[CNT_W-1:0];
    endfunction

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= GS_LOAD;
            cnt_q   <= '0;
            div_q   <= '0;
            fast_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            div_q   <= div_d;
            fast_q  <= fast_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        latch   = 1'b0;
        unique case (state_q)
            GS_LOAD: begin
                latch   = 1'b1;
                state_d = GS_EDGE;
            end
            GS_EDGE: begin
                if (div_q == '0) begin
                    latch   = 1'b1;
                    state_d = GS_EDGE;
                end else begin
                    state_d = GS_STRETCH;
                    cnt_d   = stretch_len(div_q);
                end
            end
            GS_STRETCH: begin
                if (cnt_q == '0) begin
                    latch   = 1'b1;
                    state_d = GS_EDGE;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            default: begin
                state_d = GS_LOAD;
            end
        endcase
        div_d  = latch ? sel_div_i   : div_q;
        fast_d = latch ? want_fast_i : fast_q;
    end

    // outputs
    always_comb begin
        tick_o = (state_q == GS_EDGE);
        fast_o = fast_q;
    end

    // R4: a divided period holds its pulse for a single cycle
    a_r4_single_pulse : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_o && div_q != '0) |=> !tick_o);

    // R9: no selection or exponent change away from a boundary
    a_r9_hold_in_period : assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_o |-> ($stable(fast_q) && $stable(div_q)));

endmodule

// File: rtl/gear_clock_sel.sv
module gear_clock_sel #(
    parameter int DIV_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [DIV_W-1:0] hi_div_i,
    input  logic [DIV_W-1:0] lo_div_i,
    input  logic             src_sel_i,
    input  logic             req_en_i,
    input  logic             irq_pend_i,
    input  logic             pwr_save_i,
    output logic             tick_o,
    output logic             fast_active_o
);

    logic [1:0]       sync_q;
    logic             irq_s;
    logic             psave_s;
    logic             want_fast;
    logic [DIV_W-1:0] sel_div;

    gear_sync #(
        .STAGES(SYNC_STAGES),
        .WIDTH (2)
    ) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   ({pwr_save_i, irq_pend_i}),
        .q_o   (sync_q)
    );

    assign irq_s   = sync_q[0];
    assign psave_s = sync_q[1];

    gear_select #(
        .DIV_W(DIV_W)
    ) u_select (
        .src_sel_i  (src_sel_i),
        .req_en_i   (req_en_i),
        .irq_s_i    (irq_s),
        .psave_s_i  (psave_s),
        .hi_div_i   (hi_div_i),
        .lo_div_i   (lo_div_i),
        .want_fast_o(want_fast),
        .sel_div_o  (sel_div)
    );

    gear_divider #(
        .DIV_W(DIV_W)
    ) u_divider (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .want_fast_i(want_fast),
        .sel_div_i  (sel_div),
        .tick_o     (tick_o),
        .fast_o     (fast_active_o)
    );

    // R2: fixed mode always starts a fast period
    a_r2_fixed_fast : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_o && !$past(src_sel_i)) |-> fast_active_o);

    // R7: masked requests never give a fast period in automatic mode
    a_r7_masked_slow : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_o && $past(src_sel_i) && !$past(req_en_i)) |-> !fast_active_o);

    // R8: no active condition leaves the slow field in charge
    a_r8_idle_slow : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_o && $past(src_sel_i) && $past(req_en_i) && !$past(irq_s) && $past(psave_s))
        |-> !fast_active_o);

    // R3: an exponent of zero on the fast field repeats the pulse
    a_r3_div_by_one : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_o && fast_active_o && $past(hi_div_i) == '0) |=> tick_o);

endmodule

// File: tb/gear_clock_sel_tb_top.sv
module gear_clock_sel_tb_top;

    localparam int DW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] hi_div, lo_div;
    logic          src_sel, req_en, irq, psave;
    logic          tick, fast;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;
    string cur_req  = "R1";

    always #5 clk = ~clk;

    gear_clock_sel #(.DIV_W(DW), .SYNC_STAGES(2)) dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .hi_div_i     (hi_div),
        .lo_div_i     (lo_div),
        .src_sel_i    (src_sel),
        .req_en_i     (req_en),
        .irq_pend_i   (irq),
        .pwr_save_i   (psave),
        .tick_o       (tick),
        .fast_active_o(fast)
    );

    task automatic check_int(input string req, input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference ----------------
    bit m_load = 1'b1, m_tick = 1'b0, m_fast = 1'b1;
    int m_left = 0;
    bit irq_hist[$];
    bit ps_hist[$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_load = 1'b1; m_tick = 1'b0; m_fast = 1'b1; m_left = 0;
            irq_hist = '{1'b0, 1'b0};
            ps_hist  = '{1'b0, 1'b0};
        end else begin
            bit want;
            int d;
            // element 0 is the value captured two edges ago
            want = !src_sel || (req_en && (irq_hist[0] || !ps_hist[0]));
            d    = want ? int'(hi_div) : int'(lo_div);
            if (m_load || m_left == 0) begin
                m_load = 1'b0;
                m_fast = want;
                m_tick = 1'b1;
                m_left = (1 << d) - 1;
            end else begin
                m_tick = 1'b0;
                m_left--;
            end
            void'(irq_hist.pop_front());
            void'(ps_hist.pop_front());
            irq_hist.push_back(irq);
            ps_hist.push_back(psave);
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check_int(cur_req, int'(tick), int'(m_tick), "tick vs model");
            check_int(cur_req, int'(fast), int'(m_fast), "status vs model");
        end
    end

    // ---------------- helpers ----------------
    task automatic wait_tick();
        @(negedge clk);
        while (!tick) @(negedge clk);
    endtask

    task automatic settle();
        repeat (3) wait_tick();
    endtask

    task automatic measure(input int exp, input string req);
        int n = 0;
        while (!tick) @(negedge clk);
        do begin
            @(negedge clk);
            n++;
        end while (!tick && n < 1000);
        check_int(req, n, exp, "period length");
    endtask

    // ---------------- stimulus ----------------
    initial begin
        hi_div = 3'd2; lo_div = 3'd5;
        src_sel = 1'b0; req_en = 1'b0; irq = 1'b0; psave = 1'b1;
        repeat (3) @(negedge clk);
        check_int("R1", int'(tick), 0, "tick in reset");
        check_int("R1", int'(fast), 1, "status in reset");
        rst_n = 1'b1;
        #1;
        check_int("R1", int'(tick), 0, "tick after release");
        check_int("R1", int'(fast), 1, "status after release");

        // R2: fixed high-speed mode ignores conditions
        cur_req = "R2";
        irq = 1'b1; req_en = 1'b1;
        settle(); measure(4, "R2");
        check_int("R2", int'(fast), 1, "fixed mode status");
        irq = 1'b0; psave = 1'b1;
        settle(); measure(4, "R2");
        check_int("R2", int'(fast), 1, "fixed mode status, idle conditions");

        // R3: divide by one
        cur_req = "R3";
        hi_div = 3'd0;
        settle();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check_int("R3", int'(tick), 1, "pulse every cycle");
        end

        // R4: ratios 8 and 128, single-cycle high phase
        cur_req = "R4";
        hi_div = 3'd3;
        settle(); measure(8, "R4");
        @(negedge clk);
        check_int("R4", int'(tick), 0, "high phase one cycle");
        hi_div = 3'd7;
        settle(); measure(128, "R4");

        // R7: mask clear forces slow field
        cur_req = "R7";
        hi_div = 3'd1; lo_div = 3'd4;
        src_sel = 1'b1; req_en = 1'b0; irq = 1'b1; psave = 1'b0;
        settle(); measure(16, "R7");
        check_int("R7", int'(fast), 0, "masked status");

        // R8: no active condition
        cur_req = "R8";
        req_en = 1'b1; irq = 1'b0; psave = 1'b1;
        settle(); measure(16, "R8");
        check_int("R8", int'(fast), 0, "idle status");

        // R5: pending interrupt
        cur_req = "R5";
        irq = 1'b1;
        settle(); measure(2, "R5");
        check_int("R5", int'(fast), 1, "interrupt status");

        // R6: normal operation flag
        cur_req = "R6";
        irq = 1'b0; psave = 1'b0;
        settle(); measure(2, "R6");
        check_int("R6", int'(fast), 1, "normal-run status");

        // R11: rewrite slow field while running
        cur_req = "R11";
        psave = 1'b1; lo_div = 3'd2;
        settle(); measure(4, "R11");
        lo_div = 3'd6;
        settle(); measure(64, "R11");

        // R9: request arriving mid-period does not cut the period
        cur_req = "R9";
        wait_tick();
        repeat (10) @(negedge clk);
        irq = 1'b1; lo_div = 3'd1;
        begin
            int n = 10;
            do begin
                @(negedge clk);
                n++;
                if (!tick) check_int("R9", int'(fast), 0, "status held mid-period");
            end while (!tick && n < 1000);
            check_int("R9", n, 64, "period kept after mid-period change");
        end
        measure(2, "R9");
        irq = 1'b0;
        settle();

        // R10: synchronizer latency
        cur_req = "R10";
        hi_div = 3'd1; lo_div = 3'd0;
        src_sel = 1'b1; req_en = 1'b1; psave = 1'b1; irq = 1'b0;
        settle();
        irq = 1'b1;
        @(negedge clk);
        irq = 1'b0;
        check_int("R10", int'(fast), 0, "one edge after pulse");
        @(negedge clk);
        check_int("R10", int'(fast), 0, "two edges after pulse");
        @(negedge clk);
        check_int("R10", int'(fast), 1, "three edges after pulse");
        repeat (8) @(negedge clk);
        check_int("R10", int'(fast), 0, "back to slow after pulse");

        // R9: pseudo-random changes at arbitrary cycles
        cur_req = "R9";
        begin
            logic [15:0] lfsr = 16'hACE1;
            for (int c = 0; c < 4000; c++) begin
                @(negedge clk);
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                if (lfsr[3:0] == 4'd0) hi_div = lfsr[6:4];
                if (lfsr[3:0] == 4'd1) lo_div = lfsr[9:7];
                if (lfsr[3:0] == 4'd2) src_sel = lfsr[11];
                if (lfsr[3:0] == 4'd3) req_en = lfsr[12];
                if (lfsr[3:0] == 4'd4) irq = lfsr[13];
                if (lfsr[3:0] == 4'd5) psave = lfsr[14];
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule